// File: doc/BRIEF.md
# Receive Byte Buffer with Interleaved Validity Reporting

This block holds received bytes between a demodulator and a host. The demodulator offers one byte per cycle, marked with start-of-packet and end-of-packet flags and carrying quality information about the symbols behind it. The host pops bytes one at a time, and each popped byte appears on `rd_data` one cycle after the request. The host may read at any time the buffer holds data, including while a packet is still arriving.

Two configuration inputs shape what is stored. `cfg_overwrite` decides what happens when a packet starts while the buffer still holds bytes: the old contents are thrown away and the new packet is stored, or the new packet is ignored completely. `cfg_vld_en` turns on validity reporting. Each accepted byte then occupies two entries, the data byte followed by a quality byte. The quality byte holds per-bit threshold flags in the two binary rate modes. In the multi-bit mode it holds a threshold bit and an erroneous-chip count.

A three-state controller tracks the packet stream. `ST_IDLE` means no packet is open. `ST_RECV` means a packet is being stored. `ST_DROP` means a packet is being discarded. A start flag in any state is a packet start. It moves the controller to `ST_RECV` when the packet is accepted, or to `ST_DROP` when it is discarded. If the same byte also ends the packet, the controller goes to `ST_IDLE` instead. An end flag on a non-start byte moves `ST_RECV` or `ST_DROP` back to `ST_IDLE`.

Top module: `rxbuf_top`

## Requirements
- R1: After reset, `empty` is 1, `count` is 0, `rd_data` is 0x00 and `ovr_seen` is 0.
- R2: Bytes stored from one packet are popped in arrival order. A pop requested in cycle N shows its byte on `rd_data` after the clock edge that ends cycle N.
- R3: The buffer holds at most 16 entries. A byte whose entries do not fit in the free space is lost, and `count` does not change.
- R4: A pop while `empty` is 1 puts 0x00 on `rd_data` and leaves `count` at 0.
- R5: The host may pop while a packet is still being received. A push and a pop in the same cycle both take effect.
- R6: With `cfg_overwrite`=0, a packet whose start byte arrives while the buffer is not empty is discarded in full, and the stored contents are unchanged.
- R7: With `cfg_overwrite`=1, a start byte arriving while the buffer is not empty empties the buffer, stores the new packet from its first byte, and sets `ovr_seen`.
- R8: `ovr_seen` stays set until a packet start arrives while the buffer is empty. That start clears it.
- R9: With `cfg_vld_en`=1, each accepted byte stores two entries. Pops return the data byte first and its quality byte second, so at most 8 data bytes fit.
- R10: When `cfg_rate_mode[1]`=0 (binary modes 00 and 01), the quality byte equals `wr_bit_ok`. Bit n is set when data bit n passed the threshold.
- R11: When `cfg_rate_mode[1]`=1 (multi-bit mode), the quality byte is `{wr_sym_ok, wr_chip_err[6:0]}`, with the threshold flag in bit 7.
- R12: A byte without a start flag is ignored when no packet is open (`ST_IDLE`). It is also ignored while a packet is being discarded (`ST_DROP`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_overwrite | input | 1 | 1: a new packet replaces a non-empty buffer; 0: the new packet is discarded |
| cfg_vld_en | input | 1 | Store a quality byte after every data byte |
| cfg_rate_mode | input | 2 | Rate mode; bit 1 set selects the multi-bit quality format |
| wr_valid | input | 1 | A received byte is offered this cycle |
| wr_sop | input | 1 | The offered byte starts a packet |
| wr_eop | input | 1 | The offered byte ends a packet |
| wr_data | input | 8 | Received data byte |
| wr_bit_ok | input | 8 | Per-bit threshold flags (binary modes) |
| wr_sym_ok | input | 1 | Symbol threshold flag (multi-bit mode) |
| wr_chip_err | input | 7 | Erroneous-chip count (multi-bit mode) |
| rd_en | input | 1 | Host pop request |
| rd_data | output | 8 | Popped byte, registered |
| empty | output | 1 | The buffer holds no entries |
| count | output | 5 | Number of stored entries |
| ovr_seen | output | 1 | Sticky: a packet replaced unread contents |

## Verification
A wrong packet state shows up at the ports in one of two ways. Bytes that should have been stored leave `count` unchanged, or bytes that should have been dropped raise `count` on the cycle after the offending push. Damaged pointers or swapped quality fields show as wrong values on `rd_data` one cycle after the pop that reaches them. An error in the capacity check shows as a `count` above 16, or as an overwritten head byte that is only seen when the buffer is drained. A failure to set or clear the sticky overwrite flag can be seen on `ovr_seen` on the cycle right after the packet start that should have changed it.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_DROP = 2'd2
    } rx_state_e;

    // Bit of the rate-mode field that selects the multi-bit quality format.
    localparam int unsigned MULTIBIT_SEL = 1;

endpackage

// File: rtl/rxbuf_flag_fmt.sv
module rxbuf_flag_fmt #(
    parameter int unsigned DW = 8
) (
    input  logic [1:0]    rate_mode,
    input  logic [DW-1:0] bit_ok,
    input  logic          sym_ok,
    input  logic [DW-2:0] chip_err,
    output logic [DW-1:0] flags
);
    import rxbuf_pkg::*;

    always_comb begin
        if (rate_mode[MULTIBIT_SEL]) begin
            flags = {sym_ok, chip_err};
        end else begin
            flags = bit_ok;
        end
    end

endmodule

// File: rtl/rxbuf_store.sv
// Circular entry store; DEPTH must be a power of two.
module rxbuf_store #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic [1:0]                   push_n,
    input  logic [DW-1:0]                wdata0,
    input  logic [DW-1:0]                wdata1,
    input  logic                         pop,
    output logic [DW-1:0]                head,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH+1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] rp, wp, wp_base;
    logic [CW-1:0] cnt, cnt_base;
    logic          pop_eff;

    always_comb begin
        wp_base  = flush ? '0 : wp;
        cnt_base = flush ? '0 : cnt;
        pop_eff  = pop && !flush && (cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp  <= '0;
            wp  <= '0;
            cnt <= '0;
        end else begin
            rp  <= flush ? '0 : rp + AW'(pop_eff);
            wp  <= wp_base + AW'(push_n);
            cnt <= cnt_base + CW'(push_n) - CW'(pop_eff);
        end
    end

    always_ff @(posedge clk) begin
        if (push_n != 2'd0) begin
            mem[wp_base] <= wdata0;
        end
        if (push_n == 2'd2) begin
            mem[wp_base + AW'(1)] <= wdata1;
        end
    end

    assign head  = mem[rp];
    assign count = cnt;

endmodule

// File: rtl/rxbuf_top.sv
module rxbuf_top #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_overwrite,
    input  logic                       cfg_vld_en,
    input  logic [1:0]                 cfg_rate_mode,
    input  logic                       wr_valid,
    input  logic                       wr_sop,
    input  logic                       wr_eop,
    input  logic [DW-1:0]              wr_data,
    input  logic [DW-1:0]              wr_bit_ok,
    input  logic                       wr_sym_ok,
    input  logic [DW-2:0]              wr_chip_err,
    input  logic                       rd_en,
    output logic [DW-1:0]              rd_data,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       ovr_seen
);
    import rxbuf_pkg::*;

    localparam int unsigned CW = $clog2(DEPTH+1);

    rx_state_e     state, state_nxt;
    logic [CW-1:0] cnt;
    logic [DW-1:0] flags, head;
    logic          buf_busy, pkt_start, take_new, drop_new, cont_byte;
    logic          flush, store_ok;
    logic [1:0]    need, push_n;
    logic [CW:0]   room;

    rxbuf_flag_fmt #(.DW(DW)) u_fmt (
        .rate_mode (cfg_rate_mode),
        .bit_ok    (wr_bit_ok),
        .sym_ok    (wr_sym_ok),
        .chip_err  (wr_chip_err),
        .flags     (flags)
    );

    rxbuf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .push_n (push_n),
        .wdata0 (wr_data),
        .wdata1 (flags),
        .pop    (rd_en),
        .head   (head),
        .count  (cnt)
    );

    // Packet decision and space check.
    always_comb begin
        buf_busy  = (cnt != '0);
        pkt_start = wr_valid && wr_sop;
        take_new  = pkt_start && (!buf_busy || cfg_overwrite);
        drop_new  = pkt_start && buf_busy && !cfg_overwrite;
        cont_byte = wr_valid && !wr_sop && (state == ST_RECV);
        flush     = take_new && buf_busy;
        need      = cfg_vld_en ? 2'd2 : 2'd1;
        room      = flush ? (CW+1)'(DEPTH) : (CW+1)'(DEPTH) - (CW+1)'(cnt);
        store_ok  = (take_new || cont_byte) && (room >= (CW+1)'(need));
        push_n    = store_ok ? need : 2'd0;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state logic.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (pkt_start && !wr_eop) begin
                    state_nxt = take_new ? ST_RECV : ST_DROP;
                end
            end
            ST_RECV, ST_DROP: begin
                if (pkt_start) begin
                    state_nxt = wr_eop ? ST_IDLE : (take_new ? ST_RECV : ST_DROP);
                end else if (wr_valid && wr_eop) begin
                    state_nxt = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            ovr_seen <= 1'b0;
        end else begin
            if (rd_en) begin
                rd_data <= buf_busy ? head : '0;
            end
            if (flush) begin
                ovr_seen <= 1'b1;
            end else if (take_new && !buf_busy) begin
                ovr_seen <= 1'b0;
            end
        end
    end

    assign empty = (cnt == '0);
    assign count = cnt;

    logic unused_drop;
    assign unused_drop = drop_new;

endmodule

// File: rtl/rxbuf_checker.sv
module rxbuf_checker #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cfg_overwrite,
    input logic                       wr_valid,
    input logic                       wr_sop,
    input logic                       rd_en,
    input logic [DW-1:0]              rd_data,
    input logic                       empty,
    input logic [$clog2(DEPTH+1)-1:0] count,
    input logic                       ovr_seen,
    input logic [1:0]                 state
);
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= ($clog2(DEPTH+1))'(DEPTH));

    a_r4_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty) |=> (rd_data == '0));

    a_r4_empty_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !wr_valid) |=> empty);

    a_r6_discard_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_sop && !empty && !cfg_overwrite && !rd_en) |=> $stable(count));

    a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_sop && !empty && cfg_overwrite) |=> ovr_seen);

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_seen && !(wr_valid && wr_sop && empty)) |=> ovr_seen);

    a_r12_idle_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_sop && (state == 2'd0) && !rd_en) |=> $stable(count));

endmodule

bind rxbuf_top rxbuf_checker #(.DEPTH(DEPTH), .DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_overwrite (cfg_overwrite),
    .wr_valid      (wr_valid),
    .wr_sop        (wr_sop),
    .rd_en         (rd_en),
    .rd_data       (rd_data),
    .empty         (empty),
    .count         (count),
    .ovr_seen      (ovr_seen),
    .state         (state)
);

// File: tb/tb_rxbuf_top.sv
`timescale 1ns/1ps
module tb_rxbuf_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_overwrite = 1'b0, cfg_vld_en = 1'b0;
    logic [1:0] cfg_rate_mode = 2'd0;
    logic       wr_valid = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0;
    logic [7:0] wr_data = '0, wr_bit_ok = '0;
    logic       wr_sym_ok = 1'b0;
    logic [6:0] wr_chip_err = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       empty;
    logic [4:0] count;
    logic       ovr_seen;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rxbuf_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_overwrite(cfg_overwrite), .cfg_vld_en(cfg_vld_en),
        .cfg_rate_mode(cfg_rate_mode), .wr_valid(wr_valid), .wr_sop(wr_sop), .wr_eop(wr_eop),
        .wr_data(wr_data), .wr_bit_ok(wr_bit_ok), .wr_sym_ok(wr_sym_ok), .wr_chip_err(wr_chip_err),
        .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .count(count), .ovr_seen(ovr_seen)
    );

    // {data, bit_ok, {sym_ok, chip_err}}
    localparam int NV = 6;
    localparam logic [23:0] VEC [NV] = '{
        24'hA5_FF_80, 24'h3C_0F_05, 24'h00_00_7F,
        24'hFF_F0_81, 24'h5A_AA_00, 24'h96_55_FE
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic sop, input logic eop, input logic [7:0] d,
                        input logic [7:0] bok, input logic [7:0] q);
        @(negedge clk);
        wr_valid = 1'b1; wr_sop = sop; wr_eop = eop; wr_data = d;
        wr_bit_ok = bok; wr_sym_ok = q[7]; wr_chip_err = q[6:0];
        @(negedge clk);
        wr_valid = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0;
    endtask

    task automatic pop(output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic drain();
        logic [7:0] v;
        while (!empty) pop(v);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 empty", empty, 1);
        check("R1 count", count, 0);
        check("R1 rd_data", rd_data, 0);
        check("R1 ovr_seen", ovr_seen, 0);

        // Table walk: validity interleave across all rate modes (R9, R10, R11)
        cfg_vld_en = 1'b1;
        for (int m = 0; m < 4; m++) begin
            cfg_rate_mode = 2'(m);
            for (int i = 0; i < NV; i++)
                push(i == 0, i == NV-1, VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
            check("R9 count pairs", count, 2*NV);
            for (int i = 0; i < NV; i++) begin
                pop(v);
                check("R9 data first", v, VEC[i][23:16]);
                pop(v);
                if (m >= 2) check("R11 multibit flags", v, VEC[i][7:0]);
                else        check("R10 binary flags", v, VEC[i][15:8]);
            end
        end

        // R9 capacity with interleave: 8 data bytes fit
        cfg_rate_mode = 2'd0;
        for (int i = 0; i < 9; i++) push(i == 0, i == 8, 8'(8'h10 + i), 8'(i), 8'h00);
        check("R9 vld capacity", count, 16);
        for (int i = 0; i < 8; i++) begin
            pop(v); check("R9 data order", v, 8'h10 + i);
            pop(v); check("R9 flag order", v, i);
        end
        cfg_vld_en = 1'b0;

        // R4 empty pop
        pop(v);
        check("R4 empty pop data", v, 0);
        check("R4 empty pop count", count, 0);

        // R12 stray byte with no packet open
        push(1'b0, 1'b0, 8'h77, 8'h00, 8'h00);
        check("R12 idle byte ignored", count, 0);

        // R2 / R3: 18-byte packet into 16 entries
        for (int i = 0; i < 18; i++) push(i == 0, i == 17, 8'(8'h40 + i), 8'h00, 8'h00);
        check("R3 full count", count, 16);
        for (int i = 0; i < 16; i++) begin
            pop(v); check("R2 order", v, 8'h40 + i);
        end
        check("R3 drained", empty, 1);

        // R5: pop mid-packet, then simultaneous push and pop
        push(1'b1, 1'b0, 8'hC1, 8'h00, 8'h00);
        push(1'b0, 1'b0, 8'hC2, 8'h00, 8'h00);
        pop(v);
        check("R5 mid-packet pop", v, 8'hC1);
        @(negedge clk);
        wr_valid = 1'b1; wr_eop = 1'b1; wr_data = 8'hC3; rd_en = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0; wr_eop = 1'b0; rd_en = 1'b0;
        check("R5 push+pop data", rd_data, 8'hC2);
        check("R5 push+pop count", count, 1);
        pop(v);
        check("R5 last byte", v, 8'hC3);

        // R6 discard policy; R12 body of a dropped packet is ignored
        cfg_overwrite = 1'b0;
        push(1'b1, 1'b0, 8'hA1, 8'h00, 8'h00);
        push(1'b0, 1'b1, 8'hA2, 8'h00, 8'h00);
        push(1'b1, 1'b0, 8'hB1, 8'h00, 8'h00);
        check("R6 discard count", count, 2);
        push(1'b0, 1'b1, 8'hB2, 8'h00, 8'h00);
        check("R12 dropped body ignored", count, 2);
        check("R6 no flag", ovr_seen, 0);
        pop(v); check("R6 kept first", v, 8'hA1);
        pop(v); check("R6 kept second", v, 8'hA2);

        // R7 overwrite policy
        cfg_overwrite = 1'b1;
        push(1'b1, 1'b0, 8'hA1, 8'h00, 8'h00);
        push(1'b0, 1'b1, 8'hA2, 8'h00, 8'h00);
        push(1'b1, 1'b0, 8'hD1, 8'h00, 8'h00);
        push(1'b0, 1'b0, 8'hD2, 8'h00, 8'h00);
        push(1'b0, 1'b1, 8'hD3, 8'h00, 8'h00);
        check("R7 overwrite count", count, 3);
        check("R7 flag set", ovr_seen, 1);
        for (int i = 0; i < 3; i++) begin
            pop(v); check("R7 new packet", v, 8'hD1 + i);
        end

        // R8 sticky until start into empty buffer
        check("R8 sticky after drain", ovr_seen, 1);
        push(1'b1, 1'b1, 8'hE1, 8'h00, 8'h00);
        check("R8 cleared", ovr_seen, 0);
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule